// File: doc/BRIEF.md
# SPI Slave Frame Decoder for Byte-Wide Memory Access

This block is the device side of a four-wire serial link. An external host lowers the active-low chip select, shifts in a 32-bit header and then one or more data bytes. The block converts each frame into accesses on an internal synchronous memory port that is one byte wide. The header holds a 16-bit start address, a one-bit direction flag and a 15-bit byte count. A count of one gives a single access. A larger count gives a burst: the data bytes follow the header with no gap and the address steps up by one after each byte.

The serial inputs are not related to the system clock. Chip select, the serial clock and the serial data input pass through a synchronizer, and the serial clock edges are detected in the system clock domain. This requires each high phase and each low phase of the serial clock to last at least six system clocks. Both clock-idle-low (mode 0) and clock-idle-high (mode 3) hosts are supported. Input bits are taken on rising serial clock edges, and returned read data changes after falling edges. For a read, the byte at each address is fetched from memory in the short window between the last rising edge of the previous byte and the falling edge that presents the new byte's first bit.

Top module: `spi_frame_decoder`

## Requirements
- R1: The 32-bit header is taken MSB first as address[15:0], then one direction bit, then length[14:0]. The direction bit is bit 7 of the third header byte and the length's upper seven bits are bits 6:0 of that byte. The first memory access uses the full 16-bit header address, and the number of accesses follows the full 15-bit length.
- R2: A direction bit of 1 selects a write. Each completed data byte is written to memory with a `mem_wr_en` pulse that lasts exactly one system clock. A direction bit of 0 selects a read.
- R3: Mode 0 and mode 3 hosts get identical results. MOSI is sampled on rising SCLK edges. While MISO is enabled, it changes only in the system clock that follows a detected falling SCLK edge.
- R4: A length of 1 makes one access. A length N > 1 makes N accesses at consecutive addresses, and the address presented after each write is one higher than the address of that write.
- R5: Exactly `length` bytes are transferred. Further write bytes cause no memory write. Further read slots return 0x00 on MISO.
- R6: A length of 0 causes no memory access. MISO stays 0 until chip select rises.
- R7: If chip select rises partway through a byte, the partial byte is dropped and not written. The next frame is decoded from its first header bit.
- R8: `spi_miso_oe` is low whenever chip select has been high for three system clocks and high while a frame is in progress. MISO is 0 throughout the header and throughout write frames.
- R9: For a read, the byte for address N is fetched with a one-clock `mem_rd_en` pulse, is captured one clock later, and appears on MISO MSB first in the slot of byte N. A read of length L ≥ 1 over K clocked bytes makes 1 + min(K, L−1) fetches.
- R10: `mem_wr_en` and `mem_rd_en` are never high in the same cycle.
- R11: During and straight after reset, `spi_miso_oe`, `spi_miso`, `mem_wr_en` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, asynchronous |
| spi_cs_n | input | 1 | Chip select from the host, active low, asynchronous |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| mem_addr | output | 16 | Memory byte address |
| mem_wr_en | output | 1 | Memory write strobe, one clock per byte |
| mem_wdata | output | 8 | Memory write data |
| mem_rd_en | output | 1 | Memory read strobe; data is returned one clock later |
| mem_rdata | input | 8 | Memory read data, valid one clock after `mem_rd_en` |

## Verification
Two pairs of events can fall close together. The first pair is the refill of the read shift register with the next fetched byte and the falling SCLK edge that must already present that byte's MSB. The second pair is the write of the last complete byte and the release of chip select. The bench drives back-to-back bursts in both clock modes with a half period of ten system clocks, which leaves only a few clocks of slack between fetch and shift. It compares every returned byte with its own memory model and checks the number of fetches. It also ends frames straight after the final bit, and once in the middle of a byte, and then checks which bytes reached memory and which neighbouring bytes were left unchanged.

// File: rtl/spi_fd_pkg.sv
`timescale 1ns/1ps
// Shared types of the serial frame decoder.
package spi_fd_pkg;
    // Frame phase: collecting header, moving data, or waiting for chip select release.
    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/spi_fd_sync.sv
`timescale 1ns/1ps
// Multi-bit level synchronizer.
// Each bit passes through its own flop chain of STAGES flops.
// Assumes that the bits are independent and need not arrive together.
module spi_fd_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the asynchronous level through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_fd_rx.sv
`timescale 1ns/1ps
// Receive shifter and bit counter.
// Counts HDR_BITS bits while in the header phase and DATA_W bits per byte after it.
// Assumes that sclk_rise and mosi_bit come from the same synchronized sample time.
module spi_fd_rx #(
    parameter int HDR_BITS = 32,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_act,
    input  logic                sclk_rise,
    input  logic                mosi_bit,
    input  logic                in_hdr,
    output logic                hdr_done,
    output logic [HDR_BITS-1:0] hdr_word,
    output logic                byte_done,
    output logic [DATA_W-1:0]   byte_val
);
    localparam int CNT_W = $clog2(HDR_BITS);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]    cnt;
    logic [HDR_BITS-2:0] sr;

    // Shift in one MOSI bit per rising edge and wrap the counter at the boundary of each field.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            cnt <= '0;
            sr  <= '0;
        end else if (sclk_rise) begin
            sr <= {sr[HDR_BITS-3:0], mosi_bit};
            if (in_hdr) cnt <= (cnt == HDR_LAST)  ? '0 : cnt + 1'b1;
            else        cnt <= (cnt == BYTE_LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign hdr_done  = cs_act && sclk_rise && in_hdr && (cnt == HDR_LAST);
    assign hdr_word  = {sr, mosi_bit};
    assign byte_done = cs_act && sclk_rise && !in_hdr && (cnt == BYTE_LAST);
    assign byte_val  = {sr[DATA_W-2:0], mosi_bit};
endmodule

// File: rtl/spi_fd_ctrl.sv
`timescale 1ns/1ps
// Frame controller: decodes the header, tracks the address and the remaining count, drives the memory port.
// Assumes that header and data events are at least several clocks apart (slow SCLK).
// A complete write byte still reaches memory after chip select has been released.
module spi_fd_ctrl
    import spi_fd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W = 15,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_act,
    input  logic                   hdr_done,
    input  logic [ADDR_W+LEN_W:0]  hdr_word,
    input  logic                   byte_done,
    input  logic [DATA_W-1:0]      byte_val,
    output phase_e                 phase,
    output logic                   op_wr,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic                   mem_wr_en,
    output logic [DATA_W-1:0]      mem_wdata,
    output logic                   mem_rd_en,
    output logic                   tx_load
);
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_pend, step_pend, fetch_pend, load_pend;

    logic [ADDR_W-1:0] h_addr;
    logic              h_op;
    logic [LEN_W-1:0]  h_len;

    assign h_addr = hdr_word[ADDR_W+LEN_W -: ADDR_W];
    assign h_op   = hdr_word[LEN_W];
    assign h_len  = hdr_word[LEN_W-1:0];

    // Sequence header capture, per-byte accounting and the one-clock memory strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_HDR;
            op_wr      <= 1'b0;
            addr_q     <= '0;
            rem_q      <= '0;
            wdata_q    <= '0;
            wr_pend    <= 1'b0;
            step_pend  <= 1'b0;
            fetch_pend <= 1'b0;
            load_pend  <= 1'b0;
        end else begin
            wr_pend    <= 1'b0;
            step_pend  <= 1'b0;
            fetch_pend <= 1'b0;
            load_pend  <= fetch_pend && cs_act;
            if (wr_pend || step_pend) addr_q <= addr_q + 1'b1;
            if (step_pend && cs_act && rem_q != '0) fetch_pend <= 1'b1;

            if (!cs_act) begin
                phase <= PH_HDR;
            end else begin
                unique case (phase)
                    PH_HDR: if (hdr_done) begin
                        addr_q <= h_addr;
                        op_wr  <= h_op;
                        rem_q  <= h_len;
                        phase  <= (h_len == '0) ? PH_DONE : PH_DATA;
                        if (!h_op && h_len != '0) fetch_pend <= 1'b1;
                    end
                    PH_DATA: if (byte_done) begin
                        rem_q <= rem_q - 1'b1;
                        if (rem_q == LEN_W'(1)) phase <= PH_DONE;
                        if (op_wr) begin
                            wr_pend <= 1'b1;
                            wdata_q <= byte_val;
                        end else begin
                            step_pend <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wr_en = wr_pend;
    assign mem_wdata = wdata_q;
    assign mem_rd_en = fetch_pend;
    assign tx_load   = load_pend;
endmodule

// File: rtl/spi_fd_tx.sv
`timescale 1ns/1ps
// Transmit shifter: presents read data on MISO MSB first, one bit per falling SCLK edge.
// Assumes that a load never falls in the same clock as a falling edge (refill slack).
module spi_fd_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_fall,
    input  logic              shift_en,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic              miso
);
    logic [DATA_W-1:0] sr;

    // Refill from memory, or move the next bit out on a falling edge; clear while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            sr   <= '0;
            miso <= 1'b0;
        end else if (load) begin
            sr <= load_val;
        end else if (sclk_fall && shift_en) begin
            miso <= sr[DATA_W-1];
            sr   <= {sr[DATA_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_frame_decoder.sv
`timescale 1ns/1ps
// Serial slave that turns header-plus-data frames into byte accesses on a synchronous memory port.
// Assumes that the system clock oversamples SCLK: each SCLK phase lasts at least six system clocks.
// Works with mode 0 and mode 3 hosts without configuration.
module spi_frame_decoder
    import spi_fd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W = 15,
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd_en,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int HDR_BITS = ADDR_W + 1 + LEN_W;

    logic [2:0]          s_in;
    logic                s_cs_n, s_sclk, s_mosi, sclk_prev;
    logic                cs_act, sclk_rise, sclk_fall;
    logic                hdr_done, byte_done, op_wr, tx_load;
    logic [HDR_BITS-1:0] hdr_word;
    logic [DATA_W-1:0]   byte_val;
    phase_e              phase;

    spi_fd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_cs_n, spi_sclk, spi_mosi}), .q(s_in)
    );
    assign {s_cs_n, s_sclk, s_mosi} = s_in;

    // Keep the previous synchronized SCLK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= s_sclk;
    end

    assign cs_act    = !s_cs_n;
    assign sclk_rise = s_sclk && !sclk_prev;
    assign sclk_fall = !s_sclk && sclk_prev;

    spi_fd_rx #(.HDR_BITS(HDR_BITS), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
        .mosi_bit(s_mosi), .in_hdr(phase == PH_HDR),
        .hdr_done(hdr_done), .hdr_word(hdr_word),
        .byte_done(byte_done), .byte_val(byte_val)
    );

    spi_fd_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
        .hdr_done(hdr_done), .hdr_word(hdr_word),
        .byte_done(byte_done), .byte_val(byte_val),
        .phase(phase), .op_wr(op_wr),
        .mem_addr(mem_addr), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
        .mem_rd_en(mem_rd_en), .tx_load(tx_load)
    );

    spi_fd_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
        .shift_en(phase != PH_HDR && !op_wr),
        .load(tx_load), .load_val(mem_rdata), .miso(spi_miso)
    );

    assign spi_miso_oe = cs_act;
endmodule

// File: rtl/spi_fd_checker.sv
`timescale 1ns/1ps
// Protocol checker for spi_frame_decoder, attached with bind.
// Observes the ports and the internal falling-edge pulse of the serial clock.
module spi_fd_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_miso,
    input logic              spi_miso_oe,
    input logic              mem_wr_en,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              sclk_fall
);
    logic [2:0] since_rst;

    // Count clocks since reset so that $past never reaches back into reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
    end

    p_wr_rd_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_en && mem_rd_en));

    p_oe_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_miso_oe);

    p_miso_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_miso_oe |=> !spi_miso);

    p_miso_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd1 && spi_miso_oe && $past(spi_miso_oe) && spi_miso != $past(spi_miso))
        |-> $past(sclk_fall));

    p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !mem_wr_en);

    p_rd_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    p_burst_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> mem_addr == $past(mem_addr) + ADDR_W'(1));
endmodule

bind spi_frame_decoder spi_fd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .sclk_fall(sclk_fall)
);

// File: tb/spi_frame_decoder_bench.sv
`timescale 1ns/1ps
// Bench: a table of frames walked by one loop, then directed reset, abort and strobe checks.
module spi_frame_decoder_bench;
    localparam int HALF = 40;   // SCLK half period in ns (10 system clocks)
    localparam int NV = 10;

    typedef struct packed {
        logic        mode;   // 0: clock idles low, 1: clock idles high
        logic        wr;
        logic [15:0] addr;
        logic [14:0] len;
        logic [3:0]  nb;     // data bytes clocked by the host
        logic [7:0]  seed;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 16'h1234, 15'd1,   4'd1, 8'hA5},
        '{1'b0, 1'b0, 16'h1234, 15'd1,   4'd1, 8'h00},
        '{1'b1, 1'b1, 16'h0040, 15'd5,   4'd5, 8'h10},
        '{1'b1, 1'b0, 16'h0040, 15'd5,   4'd5, 8'h00},
        '{1'b0, 1'b1, 16'h00F0, 15'd3,   4'd5, 8'h6C},
        '{1'b0, 1'b0, 16'h00F0, 15'd3,   4'd5, 8'h00},
        '{1'b1, 1'b1, 16'h0080, 15'd0,   4'd2, 8'hEE},
        '{1'b0, 1'b0, 16'h0080, 15'd0,   4'd2, 8'h00},
        '{1'b1, 1'b1, 16'h0200, 15'd256, 4'd3, 8'h33},
        '{1'b0, 1'b0, 16'h7F10, 15'd260, 4'd4, 8'h00}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso, miso_oe, wr_en, rd_en;
    logic [15:0] addr;
    logic [7:0]  wdata, rdata;

    logic [7:0]  ram [256];
    logic [7:0]  shadow [256];
    logic [15:0] wr_log [64];
    int          wr_cnt, rd_cnt, both_cnt;
    int          n_chk = 0, n_err = 0;
    logic [7:0]  tx_buf [16];
    logic [7:0]  rx_buf [16];
    logic        cur_mode = 1'b0, hdr_or, oe_mid;

    always #2 clk = ~clk;   // 250 MHz

    spi_frame_decoder u_spi_frame_decoder (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .mem_addr(addr), .mem_wr_en(wr_en),
        .mem_wdata(wdata), .mem_rd_en(rd_en), .mem_rdata(rdata)
    );

    function automatic logic [7:0] pat(int i);
        return 8'(i * 37 + 5);
    endfunction

    // Memory model with one clock of read latency, plus strobe counters.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) ram[i] <= pat(i);
            rdata <= '0; wr_cnt <= 0; rd_cnt <= 0; both_cnt <= 0;
        end else begin
            if (wr_en) begin
                ram[addr[7:0]] <= wdata;
                wr_log[wr_cnt % 64] <= addr;
                wr_cnt <= wr_cnt + 1;
            end
            if (rd_en) begin
                rdata  <= ram[addr[7:0]];
                rd_cnt <= rd_cnt + 1;
            end
            if (wr_en && rd_en) both_cnt <= both_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Clock n bits of tx (MSB first); capture MISO just before each rising edge.
    task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            if (cur_mode) sclk = 1'b0;
            mosi = tx[i];
            #(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            #(HALF);
            if (!cur_mode) sclk = 1'b0;
        end
    endtask

    task automatic open_frame(input logic m, input logic w, input logic [15:0] a, input logic [14:0] l);
        logic [7:0] r;
        logic [7:0] hdr [4];
        @(negedge clk);
        cur_mode = m;
        sclk = m;
        #(2 * HALF);
        cs_n = 1'b0;
        #(HALF);
        hdr = '{a[15:8], a[7:0], {w, l[14:8]}, l[7:0]};
        hdr_or = 1'b0;
        for (int b = 0; b < 4; b++) begin
            xfer_bits(hdr[b], 8, r);
            hdr_or = hdr_or | (|r);
        end
        oe_mid = miso_oe;
    endtask

    task automatic close_frame();
        #(HALF);
        cs_n = 1'b1;
        #(2 * HALF);
    endtask

    task automatic run_frame(input logic m, input logic w, input logic [15:0] a,
                             input logic [14:0] l, input int nb);
        logic [7:0] r;
        open_frame(m, w, a, l);
        for (int i = 0; i < nb; i++) begin
            xfer_bits(tx_buf[i], 8, r);
            rx_buf[i] = r;
        end
        close_frame();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = pat(i);
        repeat (4) @(negedge clk);
        chk("R11 oe in reset", 32'(miso_oe), 0);
        chk("R11 strobes in reset", {30'd0, wr_en, rd_en}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 outputs after reset", {29'd0, miso_oe, miso, wr_en, rd_en}, 0);

        for (int v = 0; v < NV; v++) begin
            vec_t vc;
            int   wc0, rc0, nb, ln, nacc;
            string dtag;
            vc = VECS[v];
            nb = int'(vc.nb);
            ln = int'(vc.len);
            nacc = (ln < nb) ? ln : nb;
            dtag = vc.mode ? "R3 mode-3 data" :
                   (ln == 0) ? "R6 zero length" :
                   (nb > ln) ? "R5 excess bytes ignored" :
                   (ln > 1)  ? "R4 burst data" : "R2 single byte";
            for (int i = 0; i < nb; i++) tx_buf[i] = vc.wr ? (vc.seed ^ 8'(i * 17)) : 8'hC3;
            wc0 = wr_cnt;
            rc0 = rd_cnt;
            run_frame(vc.mode, vc.wr, vc.addr, vc.len, nb);
            chk("R8 oe during frame", 32'(oe_mid), 1);
            chk("R8 MISO low in header", 32'(hdr_or), 0);
            chk("R8 oe released", 32'(miso_oe), 0);
            if (vc.wr) begin
                chk("R1 length field sets write count", 32'(wr_cnt - wc0), 32'(nacc));
                if (nacc > 0) chk("R1 header address", 32'(wr_log[wc0 % 64]), 32'(vc.addr));
                for (int i = 0; i < nacc; i++) shadow[8'(vc.addr + 16'(i))] = tx_buf[i];
                for (int i = 0; i <= nb; i++)
                    chk(dtag, 32'(ram[8'(vc.addr + 16'(i))]), 32'(shadow[8'(vc.addr + 16'(i))]));
            end else begin
                chk("R9 fetch count", 32'(rd_cnt - rc0),
                    (ln == 0) ? 0 : 32'(1 + ((nb < ln - 1) ? nb : ln - 1)));
                for (int i = 0; i < nb; i++)
                    chk(dtag, 32'(rx_buf[i]),
                        (i < ln) ? 32'(shadow[8'(vc.addr + 16'(i))]) : 0);
            end
        end

        // R7: abort in the middle of the second data byte of a 4-byte write.
        begin
            int wc0;
            logic [7:0] r;
            wc0 = wr_cnt;
            open_frame(1'b0, 1'b1, 16'h0050, 15'd4);
            xfer_bits(8'h5A, 8, r);
            xfer_bits(8'hFF, 3, r);
            close_frame();
            shadow[8'h50] = 8'h5A;
            chk("R7 only whole byte written", 32'(wr_cnt - wc0), 1);
            chk("R7 whole byte kept", 32'(ram[8'h50]), 32'h5A);
            chk("R7 partial byte dropped", 32'(ram[8'h51]), 32'(shadow[8'h51]));
            tx_buf[0] = 8'h99;
            run_frame(1'b0, 1'b1, 16'h0060, 15'd1, 1);
            shadow[8'h60] = 8'h99;
            chk("R7 next frame decodes from bit 0", 32'(ram[8'h60]), 32'h99);
            chk("R7 neighbour untouched", 32'(ram[8'h61]), 32'(shadow[8'h61]));
        end

        chk("R10 no simultaneous strobes", 32'(both_cnt), 0);
        summary();
        $finish;
    end
endmodule